// File: doc/BRIEF.md
# SPI Controller Register Front End

This block sits between a 32-bit register bus and the serial shift engine of an SPI controller. Software writes transmit words and reads receive words through two data registers. It also programs a control word and an interrupt-enable mask, and reads a status word. The block owns both word FIFOs. It decides when a bus access may push or pop them, and it derives the status flags from their occupancy. Two sticky event flags record receive overflow and transfer completion, and each is cleared by writing a one to its bit.

The shift engine is outside the block. It pops transmit words, pushes receive words and strobes a completion event through dedicated ports. The interrupt line is a level. It is high while any status bit is set and also enabled in the mask. Writing the control register with its enable bit low is a soft reset. It wipes every register and both FIFOs, and a one-cycle pulse tells the engine to drop any partly sent burst.

Bus accesses are single-cycle and word aligned. The register index is the byte address with its two low bits dropped. Read data is combinational during the cycle that `bus_rd` is high, and any FIFO pop takes effect at the end of that cycle.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After reset the status word reads 0x00000003, the control and enable registers read 0, `irq` is low and `eng_tx_valid` is low.
- R2: The status bits are live and follow FIFO occupancy from the cycle after each push or pop. Bit 0 is transmit empty. Bit 1 is transmit request, meaning the transmit count is at most `TX_REQ_LEVEL`. Bit 2 is transmit full. Bit 3 is receive ready, meaning the receive FIFO is not empty. Bit 4 is receive full. Bits 31..7 read 0.
- R3: Bit 5 (overflow) becomes set when the engine pushes while the receive FIFO is full, and that word is dropped. Bit 6 (complete) becomes set on an `eng_done` strobe. Both bits stay set until they are cleared.
- R4: A write to the status register (index 4) clears bit 5 and/or bit 6 where the written data has a one. It changes no other bit. A set event in the same cycle wins over the clear.
- R5: `irq` is high exactly when the status word ANDed with the enable register (index 3) is nonzero, in the same cycle.
- R6: Reading index 0 returns 0 while control bit 0 is low, and 0xDEADBEEF while enabled with an empty receive FIFO. Otherwise it returns the oldest receive word and pops it, so words come out in push order.
- R7: A write to index 1 is ignored while control bit 0 is low or the transmit FIFO is full. Otherwise the word is queued, and `eng_tx_word` and `eng_tx_valid` present the queue head in order to the engine's `eng_tx_pop`.
- R8: Reading index 1 returns 0 and writing index 0 has no effect. Indices 5 and above read 0 and ignore writes.
- R9: Writing index 2 with bit 0 low clears the control and enable registers and both sticky bits, and empties both FIFOs. `soft_clr` pulses high in the following cycle.
- R10: Index 2 and index 3 read back the last value written. `ctrl_word` always shows the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, else 0 |
| ctrl_word | output | 32 | Current control register for the shift engine |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_word | output | 32 | Transmit FIFO head word |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| eng_done | input | 1 | Transfer-complete event strobe |
| soft_clr | output | 1 | One-cycle pulse after a soft reset |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a full receive FIFO that receives one more engine push, in the same cycle as a status write that tries to clear the overflow bit. The FIFO takes 64 back-to-back pushes before that cycle can happen. The stimulus drives those pushes with no reads in between. It then lines up the extra push with the clear, and also lines up a completion strobe with its own clear. A long random phase follows. It mixes these collisions with soft resets that land while both FIFOs hold data, and with reads of an empty FIFO, disabled accesses and unmapped offsets.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
   // register indices (byte offset >> 2)
   localparam int unsigned IDX_RXD  = 0;
   localparam int unsigned IDX_TXD  = 1;
   localparam int unsigned IDX_CTL  = 2;
   localparam int unsigned IDX_IEN  = 3;
   localparam int unsigned IDX_STAT = 4;
   localparam int unsigned NUM_REGS = 5;

   // status bit positions
   localparam int unsigned ST_TE   = 0;
   localparam int unsigned ST_TREQ = 1;
   localparam int unsigned ST_TF   = 2;
   localparam int unsigned ST_RR   = 3;
   localparam int unsigned ST_RF   = 4;
   localparam int unsigned ST_RO   = 5;
   localparam int unsigned ST_TC   = 6;
   localparam int unsigned ST_W    = 7;

   localparam int unsigned CTL_EN  = 0;

   localparam logic [31:0] EMPTY_FILL = 32'hDEAD_BEEF;

   typedef struct packed {
      logic tc;
      logic ro;
      logic rf;
      logic rr;
      logic tf;
      logic treq;
      logic te;
   } stat_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full
);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_word_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_word_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));                                              // R2
   AST_FIFO_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);                                                     // R9
   AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);                           // R7
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
   import spi_csr_pkg::*;
#(
   parameter int unsigned DEPTH        = 64,
   parameter int unsigned TX_REQ_LEVEL = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned NSTK  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             ovf_evt,
   input  logic             done_evt,
   input  logic [NSTK-1:0]  clr_req,   // [0] overflow, [1] complete
   input  logic             wipe,
   input  logic [ST_W-1:0]  ien,
   output logic [31:0]      stat_word,
   output logic             irq
);
   if (TX_REQ_LEVEL > DEPTH) begin : g_bad_req
      $error("spi_stat_flags: TX_REQ_LEVEL exceeds DEPTH");
   end

   stat_t            st;
   logic [NSTK-1:0]  stk_set;
   logic [NSTK-1:0]  stk_q;

   assign stk_set = {done_evt, ovf_evt};

   for (genvar g = 0; g < NSTK; g++) begin : g_stk
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= 1'b0;
         else if (wipe)       q <= 1'b0;
         else if (stk_set[g]) q <= 1'b1;
         else if (clr_req[g]) q <= 1'b0;
      end
      assign stk_q[g] = q;
   end

   // occupancy-derived flags are combinational on the count registers
   always_comb begin
      st.te   = (tx_count == '0);
      st.treq = (tx_count <= CNT_W'(TX_REQ_LEVEL));
      st.tf   = (tx_count == CNT_W'(DEPTH));
      st.rr   = (rx_count != '0);
      st.rf   = (rx_count == CNT_W'(DEPTH));
      st.ro   = stk_q[0];
      st.tc   = stk_q[1];
   end

   assign stat_word = {{(32-ST_W){1'b0}}, st};
   assign irq       = |(st & ien);

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien != '0));                                                 // R5
   AST_RO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[ST_RO] && !clr_req[0] && !wipe) |=> stat_word[ST_RO]);     // R3
   AST_TC_SET_BY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt && !wipe) |=> stat_word[ST_TC]);                            // R3
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[0] && !ovf_evt) |=> !stat_word[ST_RO]);                      // R4
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
   import spi_csr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 6,
   parameter int unsigned FIFO_DEPTH   = 64,
   parameter int unsigned TX_REQ_LEVEL = FIFO_DEPTH / 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       ctrl_word,
   input  logic              eng_tx_pop,
   output logic [31:0]       eng_tx_word,
   output logic              eng_tx_valid,
   input  logic              eng_rx_push,
   input  logic [31:0]       eng_rx_word,
   input  logic              eng_done,
   output logic              soft_clr,
   output logic              irq
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("spi_ctrl_regs: ADDR_W too small for the register map");
   end

   logic [IDX_W-1:0] idx;
   logic             unused_lo;
   logic             in_map, sel_rxd, sel_txd, sel_ctl, sel_ien, sel_stat;
   logic             enabled, clear_cmd;
   logic [31:0]      ctrl_q, ien_q, stat_word;
   logic             soft_q;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic [CNT_W-1:0] tx_count, rx_count;
   logic [31:0]      rx_head;
   logic             tx_push, tx_pop, rx_push, rx_pop, rx_drop, stat_wr;

   // ---------------- address decode ----------------
   assign idx       = bus_addr[ADDR_W-1:2];
   assign unused_lo = ^bus_addr[1:0];
   assign in_map    = (idx < IDX_W'(NUM_REGS));
   assign sel_rxd   = (idx == IDX_W'(IDX_RXD));
   assign sel_txd   = (idx == IDX_W'(IDX_TXD));
   assign sel_ctl   = (idx == IDX_W'(IDX_CTL));
   assign sel_ien   = (idx == IDX_W'(IDX_IEN));
   assign sel_stat  = (idx == IDX_W'(IDX_STAT));

   assign enabled   = ctrl_q[CTL_EN];
   assign clear_cmd = bus_wr && sel_ctl && !bus_wdata[CTL_EN];

   // ---------------- FIFO gating ----------------
   assign tx_push = bus_wr && sel_txd && enabled && !tx_full;
   assign tx_pop  = eng_tx_pop && !tx_empty;
   assign rx_pop  = bus_rd && sel_rxd && enabled && !rx_empty;
   assign rx_push = eng_rx_push && !rx_full;
   assign rx_drop = eng_rx_push && rx_full;
   assign stat_wr = bus_wr && sel_stat;

   spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clear_cmd),
      .push      (tx_push),
      .push_data (bus_wdata),
      .pop       (tx_pop),
      .head      (eng_tx_word),
      .count     (tx_count),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clear_cmd),
      .push      (rx_push),
      .push_data (eng_rx_word),
      .pop       (rx_pop),
      .head      (rx_head),
      .count     (rx_count),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   spi_stat_flags #(.DEPTH(FIFO_DEPTH), .TX_REQ_LEVEL(TX_REQ_LEVEL)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_count  (tx_count),
      .rx_count  (rx_count),
      .ovf_evt   (rx_drop),
      .done_evt  (eng_done),
      .clr_req   ({stat_wr && bus_wdata[ST_TC], stat_wr && bus_wdata[ST_RO]}),
      .wipe      (clear_cmd),
      .ien       (ien_q[ST_W-1:0]),
      .stat_word (stat_word),
      .irq       (irq)
   );

   // ---------------- control / enable registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
         soft_q <= 1'b0;
      end else begin
         soft_q <= clear_cmd;
         if (clear_cmd) begin
            ctrl_q <= '0;
            ien_q  <= '0;
         end else begin
            if (bus_wr && sel_ctl) ctrl_q <= bus_wdata;
            if (bus_wr && sel_ien) ien_q  <= bus_wdata;
         end
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && in_map) begin
         if (sel_rxd)       bus_rdata = !enabled ? '0 : (rx_empty ? EMPTY_FILL : rx_head);
         else if (sel_ctl)  bus_rdata = ctrl_q;
         else if (sel_ien)  bus_rdata = ien_q;
         else if (sel_stat) bus_rdata = stat_word;
      end
   end

   assign ctrl_word    = ctrl_q;
   assign eng_tx_valid = !tx_empty;
   assign soft_clr     = soft_q;

   AST_TX_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_txd && (!enabled || tx_full) && !eng_tx_pop)
      |=> (tx_count == $past(tx_count)));                                   // R7
   AST_RX_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_rxd && !eng_rx_push && !bus_rd) |=> (rx_count == $past(rx_count))); // R8
   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_map) |-> (bus_rdata == '0));                           // R8
   AST_SOFT_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |-> (ctrl_word == '0 && !eng_tx_valid && stat_word[ST_RO] == 1'b0)); // R9
   AST_CTRL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_ctl && bus_wdata[CTL_EN]) |=> (ctrl_word == $past(bus_wdata))); // R10
endmodule

// File: tb/tb_spi_ctrl_regs.sv
`timescale 1ns/1ps
module tb_spi_ctrl_regs;
   localparam int AW    = 6;
   localparam int DEPTH = 64;
   localparam int TXREQ = DEPTH / 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 0, bus_rd = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata, ctrl_word, eng_tx_word;
   logic          eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
   logic [31:0]   eng_rx_word = '0;
   logic          eng_tx_valid, soft_clr, irq;

   always #4 clk = ~clk;

   spi_ctrl_regs #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH), .TX_REQ_LEVEL(TXREQ)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_word(ctrl_word),
      .eng_tx_pop(eng_tx_pop), .eng_tx_word(eng_tx_word), .eng_tx_valid(eng_tx_valid),
      .eng_rx_push(eng_rx_push), .eng_rx_word(eng_rx_word), .eng_done(eng_done),
      .soft_clr(soft_clr), .irq(irq));

   int vectors = 0;
   int miscmp  = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   logic [31:0] m_ctrl, m_ien;
   logic        m_ro, m_tc, m_soft;

   function automatic logic [6:0] m_stat();
      logic [6:0] s;
      s[0] = (txq.size() == 0);
      s[1] = (txq.size() <= TXREQ);
      s[2] = (txq.size() == DEPTH);
      s[3] = (rxq.size() != 0);
      s[4] = (rxq.size() == DEPTH);
      s[5] = m_ro;
      s[6] = m_tc;
      return s;
   endfunction

   always @(negedge clk) begin
      int          idx;
      logic [6:0]  st;
      logic [31:0] er;
      string       tag;
      bit          en, tx_full0, tx_empty0, rx_full0, rx_empty0;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_ctrl = '0; m_ien = '0; m_ro = 0; m_tc = 0; m_soft = 0;
      end else begin
         idx = int'(bus_addr) >> 2;
         st  = m_stat();
         en  = m_ctrl[0];
         er  = '0;
         tag = "R8";
         if (idx == 0) tag = "R6";
         else if (idx == 2 || idx == 3) tag = "R10";
         else if (idx == 4) tag = "R2 R3 R4";
         if (bus_rd) begin
            case (idx)
               0: er = !en ? 32'h0 : (rxq.size() == 0 ? 32'hDEADBEEF : rxq[0]);
               2: er = m_ctrl;
               3: er = m_ien;
               4: er = {25'b0, st};
               default: er = '0;
            endcase
         end
         chk(tag, "bus_rdata", bus_rdata, er);
         chk("R5", "irq", {31'b0, irq}, {31'b0, |(st & m_ien[6:0])});
         chk("R10", "ctrl_word", ctrl_word, m_ctrl);
         chk("R9", "soft_clr", {31'b0, soft_clr}, {31'b0, m_soft});
         chk("R7", "eng_tx_valid", {31'b0, eng_tx_valid}, {31'b0, txq.size() != 0});
         if (txq.size() != 0) chk("R7", "eng_tx_word", eng_tx_word, txq[0]);

         // next state, as of the coming rising edge
         tx_full0  = (txq.size() == DEPTH);
         tx_empty0 = (txq.size() == 0);
         rx_full0  = (rxq.size() == DEPTH);
         rx_empty0 = (rxq.size() == 0);
         m_soft = bus_wr && idx == 2 && !bus_wdata[0];
         if (m_soft) begin
            txq.delete(); rxq.delete();
            m_ctrl = '0; m_ien = '0; m_ro = 0; m_tc = 0;
         end else begin
            if (eng_tx_pop && !tx_empty0) void'(txq.pop_front());
            if (bus_wr && idx == 1 && en && !tx_full0) txq.push_back(bus_wdata);
            if (bus_rd && idx == 0 && en && !rx_empty0) void'(rxq.pop_front());
            if (eng_rx_push) begin
               if (rx_full0) m_ro = 1;
               else rxq.push_back(eng_rx_word);
            end
            if (bus_wr && idx == 4) begin
               if (bus_wdata[5] && !(eng_rx_push && rx_full0)) m_ro = 0;
               if (bus_wdata[6] && !eng_done) m_tc = 0;
            end
            if (eng_done) m_tc = 1;
            if (bus_wr && idx == 2) m_ctrl = bus_wdata;
            if (bus_wr && idx == 3) m_ien = bus_wdata;
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_done = 0;
   endtask

   task automatic wr(int addr, logic [31:0] d);
      bus_wr = 1; bus_addr = AW'(addr); bus_wdata = d; step(); bus_wr = 0;
   endtask

   task automatic rd(int addr);
      bus_rd = 1; bus_addr = AW'(addr); step(); bus_rd = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset values
      bus_rd = 1; bus_addr = AW'(16);
      @(negedge clk);
      chk("R1", "status after reset", bus_rdata, 32'h3);
      chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
      chk("R1", "tx valid after reset", {31'b0, eng_tx_valid}, 32'h0);
      step(); bus_rd = 0;

      // disabled: TX write dropped (R7), RX read gives 0 (R6)
      wr(4, 32'h1111_0000);
      rd(0);
      wr(12, 32'h7F);             // R10 enable register written while disabled
      wr(8, 32'h0000_0A01);       // enable
      wr(12, 32'h0000_0041);      // R5 irq via TE
      rd(8); rd(12);

      // R7 ordered transmit, engine pops
      for (int i = 0; i < 3; i++) wr(4, 32'hA000_0000 + i);
      eng_tx_pop = 1; repeat (4) step(); eng_tx_pop = 0;

      // R2/R7 fill transmit past full
      for (int i = 0; i < DEPTH + 3; i++) begin
         wr(4, 32'h5000_0000 + i);
         if (i % 16 == 0) rd(16);
      end
      rd(16);
      wr(12, 32'h0000_0004);       // R5 irq on transmit full
      eng_tx_pop = 1; repeat (DEPTH + 2) step(); eng_tx_pop = 0;

      // R3 fill receive past full, overflow
      for (int i = 0; i < DEPTH + 2; i++) begin
         eng_rx_push = 1; eng_rx_word = 32'h3000_0000 + 32'(i * 7); step();
      end
      eng_rx_push = 0;
      rd(16);
      wr(12, 32'h0000_0020);
      // R4 clear collides with another overflow push: set wins
      eng_rx_push = 1; eng_rx_word = 32'hBAD0_0001;
      wr(16, 32'h0000_0020); eng_rx_push = 0;
      rd(16);
      wr(16, 32'hFFFF_FFFF);       // R4 clear, other bits untouched
      rd(16);

      // R6 drain receive in order then empty reads
      for (int i = 0; i < DEPTH + 2; i++) rd(0);

      // R3/R4 complete flag
      eng_done = 1; step(); eng_done = 0; rd(16);
      eng_done = 1; wr(16, 32'h40); eng_done = 0; rd(16);
      wr(16, 32'h40); rd(16);

      // R8 inert accesses
      wr(0, 32'h1234_5678); rd(0); rd(4);
      wr(20, 32'hFFFF_FFFF); rd(20); wr(60, 32'h1); rd(60); rd(44);

      // R9 soft reset with data present
      for (int i = 0; i < 5; i++) begin
         wr(4, 32'hC000_0000 + i);
         eng_rx_push = 1; eng_rx_word = 32'hD000_0000 + i; step(); eng_rx_push = 0;
      end
      eng_done = 1; step(); eng_done = 0;
      wr(8, 32'h0000_0F00);
      rd(16); rd(8); rd(12); rd(0);
      wr(8, 32'h1);

      // random mixed traffic
      for (int n = 0; n < 30000; n++) begin
         int a;
         a = $urandom_range(0, 7);
         bus_addr    = AW'((a < 5) ? a * 4 : (a == 5 ? 20 : (a == 6 ? 40 : 60)));
         bus_wr      = ($urandom_range(0, 99) < 35);
         bus_rd      = ($urandom_range(0, 99) < 40);
         bus_wdata   = $urandom;
         if (a == 2) bus_wdata[0] = ($urandom_range(0, 99) < 97);
         eng_tx_pop  = ($urandom_range(0, 99) < 25);
         eng_rx_push = ($urandom_range(0, 99) < ((n / 2000) % 2 == 0 ? 20 : 70));
         eng_rx_word = $urandom;
         eng_done    = ($urandom_range(0, 99) < 5);
         step();
      end
      idle();
      step();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end
endmodule